// File: doc/BRIEF.md
# Deserializer output state controller

This block sits on the parallel output side of a serial link receiver and decides, every cycle, which output pads drive and which float. It combines the power-up input, the output-drive enable, the idle-mode select and its own link-lock state into one of five output modes. High impedance is not modelled at the pad; each pad group gets an output-enable bit, and the pad cell drives when its bit is 1. The status pad is driven high whenever its enable is 1.

The lock flag is kept in the local oscillator domain. It is set by a one-cycle acquisition-done pulse from the clock-recovery stage. It is cleared when the recovered clock has shown no edge for a set number of oscillator cycles. When the link is not locked, a register bit can route the local oscillator onto the clock output in place of the recovered clock. The switch between the two clocks is a handshake with a synchronized select per domain, so no shortened pulse reaches the clock output.

Top module: `rx_outstage_ctrl`

## Requirements
- R1: While `pwr_up` is 0, `clk_out_oe`, every bit of `data_oe` and `pass_oe` are 0, `link_locked` is 0 and `clk_out` is held low, whatever the other inputs are.
- R2: After `pwr_up` rises, `link_locked` stays 0 until a `cdr_acq_done` pulse is sampled by a rising `osc_clk` edge; the flag is 1 directly after that edge.
- R3: Not locked with `idle_sel` = 0: `clk_out_oe` = 0, `data_oe` = 0 and `pass_oe` = 1, for either value of `drive_en`.
- R4: Not locked with `idle_sel` = 1 and `drive_en` = 0: all enables are 0.
- R5: Not locked with `idle_sel` = 1 and `drive_en` = 1: `data_oe` = 0 and `pass_oe` = 0; `clk_out_oe` equals `osc_fallback_en`, and when it is 1, `clk_out` follows `osc_clk`.
- R6: Locked with `drive_en` = 0: `clk_out_oe` = 0, `data_oe` = 0 and `pass_oe` = 1, for either value of `idle_sel`.
- R7: Locked with `drive_en` = 1: `clk_out_oe` = 1, every bit of `data_oe` = 1 and `pass_oe` = 1, and `clk_out` follows `rec_clk`.
- R8: `link_locked` stays 1 while `rec_clk` keeps toggling, and falls to 0 once `LOSS_LIMIT` (16) consecutive `osc_clk` cycles pass with no recovered-clock edge seen.
- R9: A `cdr_acq_done` pulse that arrives while the recovered clock counts as lost leaves `link_locked` at 0.
- R10: The two clock gates are never open together, no `clk_out` pulse is shorter than the shorter half period of the two sources, and a recovered clock that stops does not block the switch to the oscillator.
- R11: `data_oe` is `LANES` bits wide (default 4), and all its bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running local oscillator clock; clocks all status logic |
| rec_clk | input | 1 | Clock from the recovery stage; may stop |
| pwr_up | input | 1 | 1 = operate, 0 = power down (asynchronous reset) |
| drive_en | input | 1 | Output-drive enable |
| idle_sel | input | 1 | Picks the output state used while not locked |
| cdr_acq_done | input | 1 | One-cycle pulse, synchronous to `osc_clk`, when acquisition completes |
| osc_fallback_en | input | 1 | Register bit: put the oscillator on the clock output when not locked |
| link_locked | output | 1 | Lock flag |
| clk_out | output | 1 | Glitch-free selected clock (recovered or oscillator) |
| clk_out_oe | output | 1 | Drive enable for the clock output pad |
| data_oe | output | LANES | Drive enable for each data lane pad |
| pass_oe | output | 1 | Drive enable for the self-test status pad (driven high) |

## Verification
On every oscillator cycle, the assertions check the output mode decode against the lock flag and the mode inputs. They also check that a new lock is always preceded by an acquisition pulse, that the two clock gates are never both open, and that power-down floats everything. Only the bench's scenarios can show the timing of lock loss after the recovered clock stops and that an acquisition pulse is ignored during loss. The same holds for the clock output actually following the selected source, edge for edge, and for the minimum pulse width across both switch directions.

// File: rtl/outstage_pkg.sv
`timescale 1ns/1ps
package outstage_pkg;

   // Output modes of the pad control decode
   typedef enum logic [2:0] {
      OM_OFF       = 3'd0,   // powered down, everything floats
      OM_PASS_ONLY = 3'd1,   // only the status pad drives (high)
      OM_ALL_HIZ   = 3'd2,   // everything floats while powered
      OM_FALLBACK  = 3'd3,   // not locked, oscillator may reach clock pad
      OM_ACTIVE    = 3'd4    // locked and driving
   } out_mode_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/os_sync_cell.sv
`timescale 1ns/1ps
module os_sync_cell #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("os_sync_cell: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/os_lock_tracker.sv
`timescale 1ns/1ps
module os_lock_tracker
   import outstage_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LOSS_LIMIT  = 16
) (
   input  logic osc_clk,
   input  logic osc_rst_n,
   input  logic rec_clk,
   input  logic rec_rst_n,
   input  logic acq_done,
   output logic locked,
   output logic rec_dead
);

   localparam int            CW  = cnt_width(LOSS_LIMIT);
   localparam logic [CW-1:0] LIM = CW'(LOSS_LIMIT);

   logic          rec_tog;
   logic          tog_s;
   logic          tog_d;
   logic          seen_edge;
   logic [CW-1:0] quiet_cnt;

   // Toggles once per recovered edge; survives the crossing as a level
   always_ff @(posedge rec_clk or negedge rec_rst_n) begin
      if (!rec_rst_n) rec_tog <= 1'b0;
      else            rec_tog <= ~rec_tog;
   end

   os_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .d     (rec_tog),
      .q     (tog_s)
   );

   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n) tog_d <= 1'b0;
      else            tog_d <= tog_s;
   end

   assign seen_edge = tog_s ^ tog_d;

   // Oscillator cycles since the last recovered edge, saturating at the limit
   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n)       quiet_cnt <= LIM;
      else if (seen_edge)   quiet_cnt <= '0;
      else if (quiet_cnt != LIM) quiet_cnt <= quiet_cnt + 1'b1;
   end

   assign rec_dead = (quiet_cnt == LIM);

   // Loss wins over a same-cycle acquisition pulse
   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n)    locked <= 1'b0;
      else if (rec_dead) locked <= 1'b0;
      else if (acq_done) locked <= 1'b1;
   end

endmodule

// File: rtl/os_mode_decode.sv
`timescale 1ns/1ps
module os_mode_decode
   import outstage_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             pwr_up,
   input  logic             locked,
   input  logic             drive_en,
   input  logic             idle_sel,
   input  logic             fb_allowed,
   output out_mode_t        mode,
   output logic             clk_oe,
   output logic [LANES-1:0] data_oe,
   output logic             pass_oe,
   output logic             want_rec,
   output logic             want_osc
);

   logic data_on;

   always_comb begin
      if (!pwr_up)        mode = OM_OFF;
      else if (locked)    mode = drive_en ? OM_ACTIVE : OM_PASS_ONLY;
      else if (!idle_sel) mode = OM_PASS_ONLY;
      else if (!drive_en) mode = OM_ALL_HIZ;
      else                mode = OM_FALLBACK;
   end

   always_comb begin
      data_on  = 1'b0;
      pass_oe  = 1'b0;
      want_rec = 1'b0;
      want_osc = 1'b0;
      unique case (mode)
         OM_ACTIVE: begin
            data_on  = 1'b1;
            pass_oe  = 1'b1;
            want_rec = 1'b1;
         end
         OM_PASS_ONLY: pass_oe  = 1'b1;
         OM_FALLBACK:  want_osc = fb_allowed;
         default: ;
      endcase
   end

   assign clk_oe = want_rec | want_osc;

   // One enable per lane, all from the same mode decision
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign data_oe[ln] = data_on;
   end

endmodule

// File: rtl/os_clk_switch.sv
`timescale 1ns/1ps
module os_clk_switch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic rec_clk,
   input  logic rec_rst_n,
   input  logic osc_clk,
   input  logic osc_rst_n,
   input  logic rec_dead,
   input  logic want_rec,
   input  logic want_osc,
   output logic rec_gate,
   output logic osc_gate,
   output logic clk_out
);

   logic rec_req;
   logic rec_req_s;
   logic osc_req;
   logic osc_req_s;
   logic rec_side_rst_n;

   // A stopped recovered clock cannot close its own gate; the loss flag does
   assign rec_side_rst_n = rec_rst_n & ~rec_dead;

   // Each side asks only once the other gate is seen closed
   assign rec_req = want_rec & ~osc_gate;
   assign osc_req = want_osc & ~rec_gate;

   os_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rec_sel_sync (
      .clk   (rec_clk),
      .rst_n (rec_side_rst_n),
      .d     (rec_req),
      .q     (rec_req_s)
   );

   os_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_osc_sel_sync (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .d     (osc_req),
      .q     (osc_req_s)
   );

   // Gates move only while their own clock is low
   always_ff @(negedge rec_clk or negedge rec_side_rst_n) begin
      if (!rec_side_rst_n) rec_gate <= 1'b0;
      else                 rec_gate <= rec_req_s;
   end

   always_ff @(negedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n) osc_gate <= 1'b0;
      else            osc_gate <= osc_req_s;
   end

   assign clk_out = (rec_clk & rec_gate) | (osc_clk & osc_gate);

endmodule

// File: rtl/rx_outstage_ctrl.sv
`timescale 1ns/1ps
module rx_outstage_ctrl
   import outstage_pkg::*;
#(
   parameter int LANES        = 4,
   parameter int LOSS_LIMIT   = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit OSC_FALLBACK = 1'b1
) (
   input  logic             osc_clk,
   input  logic             rec_clk,
   input  logic             pwr_up,
   input  logic             drive_en,
   input  logic             idle_sel,
   input  logic             cdr_acq_done,
   input  logic             osc_fallback_en,
   output logic             link_locked,
   output logic             clk_out,
   output logic             clk_out_oe,
   output logic [LANES-1:0] data_oe,
   output logic             pass_oe
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("rx_outstage_ctrl: LANES must be at least 1");
      end
      if (LOSS_LIMIT < 2) begin : g_bad_limit
         $error("rx_outstage_ctrl: LOSS_LIMIT must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rx_outstage_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      rst_osc_n;
   logic      rst_rec_n;
   logic      rec_dead;
   logic      fb_allowed;
   logic      want_rec;
   logic      want_osc;
   logic      rec_gate;
   logic      osc_gate;
   out_mode_t mode;

   // Asynchronous assert on power-down, release on each domain's own clock
   os_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_osc_rst (
      .clk   (osc_clk),
      .rst_n (pwr_up),
      .d     (1'b1),
      .q     (rst_osc_n)
   );

   os_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rec_rst (
      .clk   (rec_clk),
      .rst_n (pwr_up),
      .d     (1'b1),
      .q     (rst_rec_n)
   );

   os_lock_tracker #(.SYNC_STAGES(SYNC_STAGES), .LOSS_LIMIT(LOSS_LIMIT)) u_lock (
      .osc_clk   (osc_clk),
      .osc_rst_n (rst_osc_n),
      .rec_clk   (rec_clk),
      .rec_rst_n (rst_rec_n),
      .acq_done  (cdr_acq_done),
      .locked    (link_locked),
      .rec_dead  (rec_dead)
   );

   generate
      if (OSC_FALLBACK) begin : g_fallback
         assign fb_allowed = osc_fallback_en;
      end else begin : g_no_fallback
         assign fb_allowed = osc_fallback_en & 1'b0;
      end
   endgenerate

   os_mode_decode #(.LANES(LANES)) u_decode (
      .pwr_up     (pwr_up),
      .locked     (link_locked),
      .drive_en   (drive_en),
      .idle_sel   (idle_sel),
      .fb_allowed (fb_allowed),
      .mode       (mode),
      .clk_oe     (clk_out_oe),
      .data_oe    (data_oe),
      .pass_oe    (pass_oe),
      .want_rec   (want_rec),
      .want_osc   (want_osc)
   );

   os_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
      .rec_clk   (rec_clk),
      .rec_rst_n (rst_rec_n),
      .osc_clk   (osc_clk),
      .osc_rst_n (rst_osc_n),
      .rec_dead  (rec_dead),
      .want_rec  (want_rec),
      .want_osc  (want_osc),
      .rec_gate  (rec_gate),
      .osc_gate  (osc_gate),
      .clk_out   (clk_out)
   );

endmodule

// File: rtl/outstage_ctrl_chk.sv
`timescale 1ns/1ps
module outstage_ctrl_chk #(
   parameter int LANES = 4
) (
   input logic             osc_clk,
   input logic             rst_n,
   input logic             pwr_up,
   input logic             drive_en,
   input logic             idle_sel,
   input logic             cdr_acq_done,
   input logic             osc_fallback_en,
   input logic             link_locked,
   input logic             clk_out,
   input logic             clk_out_oe,
   input logic [LANES-1:0] data_oe,
   input logic             pass_oe,
   input logic             rec_gate,
   input logic             osc_gate
);

   localparam logic [LANES-1:0] ALL_ON = {LANES{1'b1}};

   always @(posedge osc_clk) begin
      if (!pwr_up) begin
         p_off_floats_r1: assert (!clk_out_oe && data_oe == '0 && !pass_oe
                                  && !link_locked && !clk_out)
            else $error("power-down output state violated");
      end
      p_gates_exclusive_r10: assert (!(rec_gate && osc_gate))
         else $error("both clock gates open");
      p_lanes_agree_r11: assert (data_oe == '0 || data_oe == ALL_ON)
         else $error("lane enables disagree");
   end

   property lock_needs_pulse;
      @(posedge osc_clk) disable iff (!rst_n)
         $rose(link_locked) |-> $past(cdr_acq_done);
   endproperty
   p_lock_needs_pulse_r2: assert property (lock_needs_pulse)
      else $error("lock rose without acquisition pulse");

   property unlocked_idle_low;
      @(posedge osc_clk) disable iff (!rst_n)
         (!link_locked && !idle_sel) |-> (pass_oe && !clk_out_oe && data_oe == '0);
   endproperty
   p_unlocked_pass_r3: assert property (unlocked_idle_low)
      else $error("unlocked, idle select low: wrong enables");

   property unlocked_float;
      @(posedge osc_clk) disable iff (!rst_n)
         (!link_locked && idle_sel && !drive_en) |-> (!pass_oe && !clk_out_oe && data_oe == '0);
   endproperty
   p_unlocked_float_r4: assert property (unlocked_float)
      else $error("unlocked, drive off: wrong enables");

   property unlocked_fallback;
      @(posedge osc_clk) disable iff (!rst_n)
         (!link_locked && idle_sel && drive_en)
            |-> (!pass_oe && data_oe == '0 && clk_out_oe == osc_fallback_en);
   endproperty
   p_unlocked_fallback_r5: assert property (unlocked_fallback)
      else $error("unlocked fallback: wrong enables");

   property locked_quiet;
      @(posedge osc_clk) disable iff (!rst_n)
         (link_locked && !drive_en) |-> (pass_oe && !clk_out_oe && data_oe == '0);
   endproperty
   p_locked_quiet_r6: assert property (locked_quiet)
      else $error("locked, drive off: wrong enables");

   property locked_active;
      @(posedge osc_clk) disable iff (!rst_n)
         (link_locked && drive_en) |-> (pass_oe && clk_out_oe && data_oe == ALL_ON);
   endproperty
   p_locked_active_r7: assert property (locked_active)
      else $error("locked, drive on: wrong enables");

endmodule

bind rx_outstage_ctrl outstage_ctrl_chk #(.LANES(LANES)) u_chk (
   .osc_clk         (osc_clk),
   .rst_n           (rst_osc_n),
   .pwr_up          (pwr_up),
   .drive_en        (drive_en),
   .idle_sel        (idle_sel),
   .cdr_acq_done    (cdr_acq_done),
   .osc_fallback_en (osc_fallback_en),
   .link_locked     (link_locked),
   .clk_out         (clk_out),
   .clk_out_oe      (clk_out_oe),
   .data_oe         (data_oe),
   .pass_oe         (pass_oe),
   .rec_gate        (rec_gate),
   .osc_gate        (osc_gate)
);

// File: tb/tb_rx_outstage_ctrl.sv
`timescale 1ns/1ps
module tb_rx_outstage_ctrl;

   localparam int LANES = 4;

   logic             osc_clk = 1'b0;
   logic             rec_clk = 1'b0;
   logic             pwr_up = 1'b0;
   logic             drive_en = 1'b0;
   logic             idle_sel = 1'b0;
   logic             cdr_acq_done = 1'b0;
   logic             osc_fallback_en = 1'b0;
   logic             link_locked;
   logic             clk_out;
   logic             clk_out_oe;
   logic [LANES-1:0] data_oe;
   logic             pass_oe;

   bit      rec_run = 1'b0;
   int      n_vec = 0;
   int      n_bad = 0;
   int      n_out = 0;
   int      n_osc = 0;
   int      n_rec = 0;
   bit      mon_en = 1'b0;
   realtime last_t = 0.0;
   realtime min_w = 1.0e9;
   bit      finished = 1'b0;

   rx_outstage_ctrl #(.LANES(LANES)) dut (
      .osc_clk         (osc_clk),
      .rec_clk         (rec_clk),
      .pwr_up          (pwr_up),
      .drive_en        (drive_en),
      .idle_sel        (idle_sel),
      .cdr_acq_done    (cdr_acq_done),
      .osc_fallback_en (osc_fallback_en),
      .link_locked     (link_locked),
      .clk_out         (clk_out),
      .clk_out_oe      (clk_out_oe),
      .data_oe         (data_oe),
      .pass_oe         (pass_oe)
   );

   // 50 MHz oscillator; recovered clock 33 MHz that stops low
   always #10 osc_clk = ~osc_clk;
   always begin
      #15;
      if (rec_run || rec_clk) rec_clk = ~rec_clk;
   end

   always @(posedge clk_out) n_out++;
   always @(posedge osc_clk) n_osc++;
   always @(posedge rec_clk) n_rec++;

   always @(clk_out) begin
      if (mon_en && last_t > 0.0 && ($realtime - last_t) < min_w)
         min_w = $realtime - last_t;
      last_t = $realtime;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act < exp - 1 || act > exp + 1 || exp < 10) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_enables(input string req, input logic c, input logic [LANES-1:0] d,
                              input logic p);
      chk(req, "clk_out_oe", {31'b0, clk_out_oe}, {31'b0, c});
      chk(req, "data_oe", {{(32-LANES){1'b0}}, data_oe}, {{(32-LANES){1'b0}}, d});
      chk(req, "pass_oe", {31'b0, pass_oe}, {31'b0, p});
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge osc_clk);
   endtask

   task automatic pulse_acq();
      @(negedge osc_clk);
      cdr_acq_done = 1'b1;
      @(negedge osc_clk);
      cdr_acq_done = 1'b0;
   endtask

   // Counts clk_out rising edges against the expected source over 40 cycles
   task automatic clk_follows(input string req, input bit use_rec);
      int o0, s0;
      cycles(20);
      o0 = n_out;
      s0 = use_rec ? n_rec : n_osc;
      cycles(40);
      chk_near(req, use_rec ? "clk_out edges vs rec_clk" : "clk_out edges vs osc_clk",
               n_out - o0, (use_rec ? n_rec : n_osc) - s0);
   endtask

   task automatic t_power_down();
      drive_en = 1'b1; idle_sel = 1'b1; osc_fallback_en = 1'b1; rec_run = 1'b1;
      cycles(5);
      #1;
      chk("R1", "lock during power-down", {31'b0, link_locked}, 32'd0);
      chk("R1", "clk_out during power-down", {31'b0, clk_out}, 32'd0);
      chk_enables("R1", 1'b0, '0, 1'b0);
   endtask

   task automatic t_power_up();
      @(negedge osc_clk);
      idle_sel = 1'b0; drive_en = 1'b0; pwr_up = 1'b1;
      mon_en = 1'b1;
      cycles(12);
      chk("R2", "lock before acquisition", {31'b0, link_locked}, 32'd0);
      chk_enables("R3", 1'b0, '0, 1'b1);
      drive_en = 1'b1;
      #1;
      chk_enables("R3", 1'b0, '0, 1'b1);
   endtask

   task automatic t_acquire();
      @(negedge osc_clk);
      cdr_acq_done = 1'b1;
      chk("R2", "lock while pulse pending", {31'b0, link_locked}, 32'd0);
      @(negedge osc_clk);
      cdr_acq_done = 1'b0;
      chk("R2", "lock after pulse edge", {31'b0, link_locked}, 32'd1);
   endtask

   task automatic t_locked();
      drive_en = 1'b0; idle_sel = 1'b1;
      #1;
      chk_enables("R6", 1'b0, '0, 1'b1);
      idle_sel = 1'b0;
      #1;
      chk_enables("R6", 1'b0, '0, 1'b1);
      drive_en = 1'b1;
      #1;
      chk_enables("R7", 1'b1, {LANES{1'b1}}, 1'b1);
      chk("R11", "lane count", 32'($bits(data_oe)), 32'(LANES));
      clk_follows("R7", 1'b1);
      cycles(100);
      chk("R8", "lock held with running clock", {31'b0, link_locked}, 32'd1);
   endtask

   task automatic t_loss();
      idle_sel = 1'b1; drive_en = 1'b1; osc_fallback_en = 1'b0;
      @(negedge osc_clk);
      rec_run = 1'b0;
      cycles(4);
      chk("R8", "lock shortly after clock stop", {31'b0, link_locked}, 32'd1);
      cycles(40);
      chk("R8", "lock after silence", {31'b0, link_locked}, 32'd0);
      chk_enables("R5", 1'b0, '0, 1'b0);
      osc_fallback_en = 1'b1;
      #1;
      chk_enables("R5", 1'b1, '0, 1'b0);
      clk_follows("R5", 1'b0);
      chk("R10", "rec gate released after stop", 32'(n_out > 0), 32'd1);
      drive_en = 1'b0;
      #1;
      chk_enables("R4", 1'b0, '0, 1'b0);
      idle_sel = 1'b0;
      #1;
      chk_enables("R3", 1'b0, '0, 1'b1);
      pulse_acq();
      cycles(3);
      chk("R9", "pulse during loss", {31'b0, link_locked}, 32'd0);
   endtask

   task automatic t_relock();
      idle_sel = 1'b1; drive_en = 1'b1; osc_fallback_en = 1'b1;
      cycles(20);
      rec_run = 1'b1;
      cycles(12);
      pulse_acq();
      chk("R2", "relock after pulse", {31'b0, link_locked}, 32'd1);
      clk_follows("R7", 1'b1);
      @(negedge osc_clk);
      rec_run = 1'b0;
      cycles(40);
      clk_follows("R5", 1'b0);
      chk("R10", "minimum clk_out pulse >= 9.5 ns", 32'(min_w >= 9.5), 32'd1);
   endtask

   task automatic t_power_off();
      rec_run = 1'b1;
      cycles(12);
      pulse_acq();
      cycles(30);
      mon_en = 1'b0;
      pwr_up = 1'b0;
      #1;
      chk("R1", "lock cleared by power-down", {31'b0, link_locked}, 32'd0);
      chk("R1", "clk_out low at power-down", {31'b0, clk_out}, 32'd0);
      chk_enables("R1", 1'b0, '0, 1'b0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_power_down();
      t_power_up();
      t_acquire();
      t_locked();
      t_loss();
      t_relock();
      t_power_off();
      cycles(5);
      finish_run();
   end

endmodule